// File: doc/BRIEF.md
# BCD digit adder cell

This block adds two decimal digits, each held as a 4-bit binary-coded value from 0 to 9, together with a one-bit incoming carry. It returns one decimal result digit and a decimal carry-out, so that several cells can be chained into a multi-digit decimal adder by linking each carry-out to the next cell's carry-in.

The cell is purely combinational and works in three stages. A ripple of full adders forms the plain binary total, which can be anything from 0 to 19. A small two-level detector decides whether that total has passed nine. It looks only at the binary carry and the upper three bits of the total, never at bit 0. When the detector fires, a correction stage adds six to the total and drops the carry of that addition. The correction stage uses one full adder and two half adders, with a full adder only at the one position that has three inputs. Bit 0 of the total passes straight through.

Top module: `bcd_digit_adder`

## Requirements
- R1: For operands 0..9 and carry-in 0 or 1, ten times `dec_carry` plus `dec_sum` equals `dig_a + dig_b + carry_in`.
- R2: For valid operands, `dec_sum` is always in the range 0..9.
- R3: `dec_carry` is 1 exactly when `dig_a + dig_b + carry_in` is 10 or more.
- R4: When the total is 9 or less, `dec_sum` equals the binary total unchanged.
- R5: Bit 0 of `dec_sum` equals the XOR of bit 0 of each operand and `carry_in`.
- R6: `carry_in` carries weight one: raising it from 0 to 1 raises the decimal result by exactly one, so that 9 + 9 + 1 gives carry 1 and digit 9.
- R7: The overflow decision does not depend on bit 0 of the binary total: totals 8 and 9 both give carry 0, and totals 10 and 11 both give carry 1.
- R8: When the total is 10 to 19, `dec_sum` is the total plus six with bit 4 and up dropped (10 gives 0, 15 gives 5, 16 gives 6, 19 gives 9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dig_a | input | 4 | First decimal operand, binary coded, 0..9 |
| dig_b | input | 4 | Second decimal operand, binary coded, 0..9 |
| carry_in | input | 1 | Decimal carry from the next lower digit |
| dec_sum | output | 4 | Result digit, binary coded, 0..9 |
| dec_carry | output | 1 | Decimal carry to the next higher digit |

## Verification
The in-line checks assume both operands are legal decimal codes. Every check that relates outputs to decimal arithmetic is guarded by a test that each operand is at most nine, so codes 10 to 15 never raise a false report. The stimulus keeps within that range. It walks a table of boundary totals such as 9, 10, 15, 16 and 19, then sweeps all 200 legal operand and carry combinations. It never applies an illegal code.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] MAX_DIGIT = 4'd9;
  localparam logic [DIGIT_W-1:0] FIX_VAL = 4'd6;
  // Threshold of ten expressed in units of two (bit 0 excluded).
  localparam logic [DIGIT_W-1:0] HALF_TEN = 4'd5;
endpackage

// File: rtl/bcd_fa.sv
module bcd_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic p;
  assign p  = x ^ y;
  assign s  = p ^ ci;
  assign co = (x & y) | (ci & p);
endmodule

// File: rtl/bcd_ha.sv
module bcd_ha (
  input  logic x,
  input  logic y,
  output logic s,
  output logic co
);
  assign s  = x ^ y;
  assign co = x & y;
endmodule

// File: rtl/bcd_bin_stage.sv
module bcd_bin_stage #(
  parameter int W = 4
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         cin,
  output logic [W-1:0] raw_sum,
  output logic         raw_carry
);
  logic [W:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_rip
    bcd_fa u_fa (
      .x (op_a[i]),
      .y (op_b[i]),
      .ci(chain[i]),
      .s (raw_sum[i]),
      .co(chain[i+1])
    );
  end

  assign raw_carry = chain[W];

  // R1: ripple total matches integer addition
  always_comb begin
    p_ripple_total_r1: assert (int'({raw_carry, raw_sum}) == int'(op_a) + int'(op_b) + int'(cin))
      else $error("ripple total mismatch");
  end
endmodule

// File: rtl/bcd_ovf_detect.sv
module bcd_ovf_detect
  import bcd_add_pkg::*;
(
  input  logic       bin_carry,
  input  logic [3:1] bin_hi,
  output logic       fix_en
);
  // Minimized sum of products; bit 0 of the total is not an input (R7).
  assign fix_en = bin_carry | (bin_hi[3] & bin_hi[2]) | (bin_hi[3] & bin_hi[1]);

  // R3: fires exactly when total/2 is at least five
  always_comb begin
    p_detect_threshold_r3: assert (fix_en == ({bin_carry, bin_hi} >= HALF_TEN))
      else $error("overflow detect disagrees with threshold");
  end
endmodule

// File: rtl/bcd_fix_stage.sv
module bcd_fix_stage (
  input  logic [3:0] bin_sum,
  input  logic       fix_en,
  output logic [3:0] fixed
);
  logic c1, c2, c3;

  assign fixed[0] = bin_sum[0];

  bcd_ha u_ha1 (.x(bin_sum[1]), .y(fix_en), .s(fixed[1]), .co(c1));
  bcd_fa u_fa2 (.x(bin_sum[2]), .y(fix_en), .ci(c1), .s(fixed[2]), .co(c2));
  bcd_ha u_ha3 (.x(bin_sum[3]), .y(c2), .s(fixed[3]), .co(c3));

  // R4: no correction leaves the total untouched
  always_comb begin
    p_pass_through_r4: assert (fix_en || (fixed == bin_sum))
      else $error("uncorrected digit altered");
  end

  // R8: totals 10..15 wrap past sixteen, so the dropped carry is set
  always_comb begin
    p_drop_carry_r8: assert (!(fix_en && bin_sum >= 4'd10) || c3)
      else $error("expected discarded carry");
  end
endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
  import bcd_add_pkg::*;
(
  input  logic [3:0] dig_a,
  input  logic [3:0] dig_b,
  input  logic       carry_in,
  output logic [3:0] dec_sum,
  output logic       dec_carry
);
  logic [DIGIT_W-1:0] bin_sum;
  logic               bin_carry;
  logic               fix_en;

  bcd_bin_stage #(.W(DIGIT_W)) u_bin (
    .op_a     (dig_a),
    .op_b     (dig_b),
    .cin      (carry_in),
    .raw_sum  (bin_sum),
    .raw_carry(bin_carry)
  );

  bcd_ovf_detect u_det (
    .bin_carry(bin_carry),
    .bin_hi   (bin_sum[3:1]),
    .fix_en   (fix_en)
  );

  bcd_fix_stage u_fix (
    .bin_sum(bin_sum),
    .fix_en (fix_en),
    .fixed  (dec_sum)
  );

  assign dec_carry = fix_en;

  logic ops_ok;
  assign ops_ok = (dig_a <= MAX_DIGIT) && (dig_b <= MAX_DIGIT);

  // R2: result is a legal digit
  always_comb begin
    p_legal_digit_r2: assert (!ops_ok || dec_sum <= MAX_DIGIT)
      else $error("illegal result digit");
  end

  // R1: decimal weighting of carry and digit
  always_comb begin
    p_decimal_total_r1: assert (!ops_ok ||
        (10 * int'(dec_carry) + int'(dec_sum) == int'(dig_a) + int'(dig_b) + int'(carry_in)))
      else $error("decimal total mismatch");
  end

  // R5: least significant result bit is the parity of the inputs
  always_comb begin
    p_lsb_parity_r5: assert (dec_sum[0] == (dig_a[0] ^ dig_b[0] ^ carry_in))
      else $error("bit 0 parity mismatch");
  end
endmodule

// File: tb/sim_bcd_digit_adder.sv
module sim_bcd_digit_adder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [3:0] dig_a = '0;
  logic [3:0] dig_b = '0;
  logic       carry_in = 1'b0;
  logic [3:0] dec_sum;
  logic       dec_carry;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bcd_digit_adder u0 (
    .dig_a(dig_a), .dig_b(dig_b), .carry_in(carry_in),
    .dec_sum(dec_sum), .dec_carry(dec_carry)
  );

  // {a, b, cin, expected digit, expected carry}
  localparam int NV = 12;
  localparam logic [13:0] VEC [NV] = '{
    {4'd0, 4'd0, 1'b0, 4'd0, 1'b0},
    {4'd9, 4'd9, 1'b1, 4'd9, 1'b1},
    {4'd9, 4'd9, 1'b0, 4'd8, 1'b1},
    {4'd5, 4'd5, 1'b0, 4'd0, 1'b1},
    {4'd4, 4'd5, 1'b0, 4'd9, 1'b0},
    {4'd4, 4'd5, 1'b1, 4'd0, 1'b1},
    {4'd7, 4'd8, 1'b0, 4'd5, 1'b1},
    {4'd8, 4'd8, 1'b0, 4'd6, 1'b1},
    {4'd9, 4'd0, 1'b1, 4'd0, 1'b1},
    {4'd0, 4'd9, 1'b0, 4'd9, 1'b0},
    {4'd3, 4'd4, 1'b1, 4'd8, 1'b0},
    {4'd6, 4'd7, 1'b0, 4'd3, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input int c);
    @(posedge clk);
    dig_a = 4'(a);
    dig_b = 4'(b);
    carry_in = c[0];
    @(negedge clk);
  endtask

  function automatic int dec_val();
    return 10 * int'(dec_carry) + int'(dec_sum);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          total++;
          bad++;
          $display("FAIL R1 watchdog actual=hung expected=finished");
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none
  end

  initial begin
    // Reset state: zero operands give zero result (R1)
    @(negedge clk);
    chk("R1 reset zero digit", int'(dec_sum), 0);
    chk("R3 reset zero carry", int'(dec_carry), 0);
    repeat (2) @(posedge clk);
    rst = 1'b0;

    // Vector table (R8 digit, R3 carry)
    for (int i = 0; i < NV; i++) begin
      apply(int'(VEC[i][13:10]), int'(VEC[i][9:6]), int'(VEC[i][5]));
      chk("R8 table digit", int'(dec_sum), int'(VEC[i][4:1]));
      chk("R3 table carry", int'(dec_carry), int'(VEC[i][0]));
    end

    // Full legal sweep
    for (int a = 0; a < 10; a++) begin
      for (int b = 0; b < 10; b++) begin
        for (int c = 0; c < 2; c++) begin
          int t;
          t = a + b + c;
          apply(a, b, c);
          chk("R1 decimal total", dec_val(), t);
          chk("R2 digit range", int'(dec_sum <= 4'd9), 1);
          chk("R3 carry", int'(dec_carry), int'(t >= 10));
          if (t < 10) chk("R4 pass through", int'(dec_sum), t);
          else chk("R8 corrected digit", int'(dec_sum), t - 10);
          chk("R5 bit0 parity", int'(dec_sum[0]), (a ^ b ^ c) & 1);
        end
      end
    end

    // R6: carry-in adds exactly one
    for (int a = 0; a < 10; a++) begin
      int v0;
      apply(a, 9 - a, 0);
      v0 = dec_val();
      apply(a, 9 - a, 1);
      chk("R6 carry-in weight", dec_val(), v0 + 1);
    end
    apply(9, 9, 1);
    chk("R6 max digit", int'(dec_sum), 9);
    chk("R6 max carry", int'(dec_carry), 1);

    // R7: totals differing only in bit 0 give the same carry
    apply(4, 4, 0);
    chk("R7 total 8 carry", int'(dec_carry), 0);
    apply(4, 4, 1);
    chk("R7 total 9 carry", int'(dec_carry), 0);
    apply(5, 5, 0);
    chk("R7 total 10 carry", int'(dec_carry), 1);
    apply(5, 5, 1);
    chk("R7 total 11 carry", int'(dec_carry), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule